// File: doc/BRIEF.md
# Rotating Register File with Rename Base

This block is a register file split into two regions. Logical numbers below a static boundary reach their physical entry directly. Logical numbers at or above the boundary are translated through a rename base. The offset of the number inside the rotating region is added to the base, modulo the size of that region.

Each loop-branch strobe decrements the base by one. A loop-carried value written under logical number X therefore shows up as X+1 in the next kernel iteration, without any data moving. Several copies of a value that is produced in successive iterations stay alive in different physical entries.

The file has two combinational read ports and one synchronous write port. The sizes of both regions are parameters. The same module serves a wide data file, with 32 static and 96 rotating entries, and a one-bit flag file, with 16 static and 48 rotating entries.

Top module: `rot_regfile`

## Requirements
- R1: A logical number below STATIC_N (default 32) always reads the value last written to that same number. The rotate strobe never changes this.
- R2: A logical number L at or above STATIC_N maps to physical entry STATIC_N + ((L - STATIC_N + base) mod ROT_N), with default ROT_N = 96. Distinct rotating logical numbers never share an entry.
- R3: Each cycle with `rotate` high decrements the base by one. In a cycle with `rotate` low the base is unchanged.
- R4: The base always lies in 0..ROT_N-1 and wraps from 0 to ROT_N-1. After ROT_N rotations, every rotating logical number again reads its original value.
- R5: After one rotation, a value written to rotating logical number X reads back at logical number X+1.
- R6: After one rotation, a value held in the highest logical number (STATIC_N+ROT_N-1) reads back at the lowest rotating number, STATIC_N.
- R7: When `wr_en` and `rotate` are high in the same cycle, the write lands under the mapping in force before that rotation.
- R8: Reads are combinational. A read of the entry being written in the same cycle returns the old contents.
- R9: A synchronous `rst` clears every entry to zero and sets the base to zero.
- R10: A value written to logical 32 reads as logical 34 after exactly two rotations. A write to logical 32 made between those rotations does not overwrite it.
- R11: With STATIC_N = 16 and ROT_N = 48, the file keeps 16 static flags and rotates entries 16..63 by the same rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rotate | input | 1 | Loop-branch strobe; steps the rename base |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Logical number to write |
| wr_data | input | DATA_W | Data to write |
| rd0_addr | input | ADDR_W | Logical number for read port 0 |
| rd0_data | output | DATA_W | Read port 0 data |
| rd1_addr | input | ADDR_W | Logical number for read port 1 |
| rd1_data | output | DATA_W | Read port 1 data |

## Verification
Two functions can coincide in one cycle: a write and a rotation, and a write and a read of the same logical number.

Both are provoked by table rows that raise `wr_en` together with `rotate`, or that read the address being written. They are also provoked by directed sequences around logical 32, the top entry and the wrap of the base.

Each case is judged against a reference model of logical contents. In that model a write is applied first, and the rotating region is then shifted up by one with wraparound. Reads are compared before each clock edge, so they must still show the old contents.

// File: rtl/rot_rf_pkg.sv
package rot_rf_pkg;

    typedef enum logic {
        REGION_STATIC   = 1'b0,
        REGION_ROTATING = 1'b1
    } rf_region_e;

    localparam int NUM_ACCESS = 3;   // two reads, one write
    localparam int ACC_WR     = 2;

endpackage

// File: rtl/rot_base_ctr.sv
module rot_base_ctr #(
    parameter int ROT_N  = 96,
    parameter int BASE_W = $clog2(ROT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rotate,
    output logic [BASE_W-1:0] base_q
);

    typedef struct packed {
        logic [BASE_W-1:0] base;
    } base_st_t;

    base_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rotate) begin
            if (st_q.base == '0) begin
                st_d.base = BASE_W'(ROT_N - 1);
            end else begin
                st_d.base = st_q.base - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_q = st_q.base;

    AST_BASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        base_q < BASE_W'(ROT_N)); // R4

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rotate |=> $stable(base_q)); // R3

    AST_BASE_MOVES: assert property (@(posedge clk) disable iff (rst)
        rotate |=> !$stable(base_q)); // R3

endmodule

// File: rtl/rot_addr_map.sv
module rot_addr_map
    import rot_rf_pkg::*;
#(
    parameter int STATIC_N = 32,
    parameter int ROT_N    = 96,
    parameter int ADDR_W   = $clog2(STATIC_N + ROT_N),
    parameter int BASE_W   = $clog2(ROT_N)
) (
    input  logic [ADDR_W-1:0] logical,
    input  logic [BASE_W-1:0] base,
    output logic [ADDR_W-1:0] phys,
    output rf_region_e        region
);

    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] offset;
    logic [SUM_W-1:0] sum_raw;
    logic [SUM_W-1:0] sum_wrap;

    always_comb begin
        offset   = SUM_W'(logical) - SUM_W'(STATIC_N);
        sum_raw  = offset + SUM_W'(base);
        sum_wrap = (sum_raw >= SUM_W'(ROT_N)) ? (sum_raw - SUM_W'(ROT_N)) : sum_raw;
        if (logical < ADDR_W'(STATIC_N)) begin
            region = REGION_STATIC;
            phys   = logical;
        end else begin
            region = REGION_ROTATING;
            phys   = ADDR_W'(sum_wrap + SUM_W'(STATIC_N));
        end
    end

endmodule

// File: rtl/rot_rf_store.sv
module rot_rf_store
    import rot_rf_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int DATA_W  = 32,
    parameter int N_RD    = 2,
    parameter int ADDR_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_phys,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_phys [N_RD],
    output logic [DATA_W-1:0] rd_data [N_RD]
);

    typedef struct packed {
        logic [ENTRIES-1:0][DATA_W-1:0] ent;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_phys] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rd_data[p] = st_q.ent[rd_phys[p]];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> st_q.ent[$past(wr_phys)] == $past(wr_data)); // R5

endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
    import rot_rf_pkg::*;
#(
    parameter int STATIC_N   = 32,
    parameter int ROT_N      = 96,
    parameter int DATA_W     = 32,
    localparam int ENTRIES   = STATIC_N + ROT_N,
    localparam int ADDR_W    = $clog2(ENTRIES),
    localparam int BASE_W    = $clog2(ROT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rotate,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [DATA_W-1:0] rd1_data
);

    logic [BASE_W-1:0] base_q;
    logic [ADDR_W-1:0] logical_a [NUM_ACCESS];
    logic [ADDR_W-1:0] phys_a    [NUM_ACCESS];
    rf_region_e        region_a  [NUM_ACCESS];
    logic [ADDR_W-1:0] rd_phys   [2];
    logic [DATA_W-1:0] rd_data   [2];

    rot_base_ctr #(
        .ROT_N  (ROT_N),
        .BASE_W (BASE_W)
    ) base_i (
        .clk    (clk),
        .rst    (rst),
        .rotate (rotate),
        .base_q (base_q)
    );

    assign logical_a[0]      = rd0_addr;
    assign logical_a[1]      = rd1_addr;
    assign logical_a[ACC_WR] = wr_addr;

    // Same translation for every access; the write also uses the pre-rotation base.
    for (genvar g = 0; g < NUM_ACCESS; g++) begin : g_map
        rot_addr_map #(
            .STATIC_N (STATIC_N),
            .ROT_N    (ROT_N),
            .ADDR_W   (ADDR_W),
            .BASE_W   (BASE_W)
        ) map_i (
            .logical (logical_a[g]),
            .base    (base_q),
            .phys    (phys_a[g]),
            .region  (region_a[g])
        );
    end

    assign rd_phys[0] = phys_a[0];
    assign rd_phys[1] = phys_a[1];

    rot_rf_store #(
        .ENTRIES (ENTRIES),
        .DATA_W  (DATA_W),
        .N_RD    (2),
        .ADDR_W  (ADDR_W)
    ) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_phys (phys_a[ACC_WR]),
        .wr_data (wr_data),
        .rd_phys (rd_phys),
        .rd_data (rd_data)
    );

    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];

    AST_STATIC_IDENT: assert property (@(posedge clk) disable iff (rst)
        (region_a[0] == REGION_STATIC) |-> (phys_a[0] == rd0_addr)); // R1

    AST_ROT_IN_REGION: assert property (@(posedge clk) disable iff (rst)
        (region_a[ACC_WR] == REGION_ROTATING) |-> (phys_a[ACC_WR] >= ADDR_W'(STATIC_N))); // R2

    AST_ROT_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (region_a[0] == REGION_ROTATING && region_a[1] == REGION_ROTATING
         && rd0_addr != rd1_addr) |-> (phys_a[0] != phys_a[1])); // R2

endmodule

// File: tb/rot_regfile_tb_top.sv
module rot_regfile_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NS = 32, NR = 96, NT = 128, AW = 7, DW = 32;
    localparam int PS = 16, PR = 48, PT = 64, PAW = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic          rotate = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd0_addr = '0, rd1_addr = '0;
    logic [DW-1:0] wr_data = '0, rd0_data, rd1_data;

    logic           p_rotate = 1'b0, p_wr_en = 1'b0;
    logic [PAW-1:0] p_wr_addr = '0, p_rd0_addr = '0, p_rd1_addr = '0;
    logic [0:0]     p_wr_data = '0, p_rd0_data, p_rd1_data;

    rot_regfile #(.STATIC_N(NS), .ROT_N(NR), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .rotate(rotate), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data));

    rot_regfile #(.STATIC_N(PS), .ROT_N(PR), .DATA_W(1)) pred_i (
        .clk(clk), .rst(rst), .rotate(p_rotate), .wr_en(p_wr_en), .wr_addr(p_wr_addr),
        .wr_data(p_wr_data), .rd0_addr(p_rd0_addr), .rd0_data(p_rd0_data),
        .rd1_addr(p_rd1_addr), .rd1_data(p_rd1_data));

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] mdl  [NT];
    logic          pmdl [PT];

    // Vector: {we, waddr[6:0], wdata[15:0], rot, ra0[6:0], ra1[6:0]}
    localparam logic [38:0] VEC [16] = '{
        {1'b1, 7'd32,  16'h1111, 1'b0, 7'd0,   7'd32 },
        {1'b1, 7'd5,   16'h0055, 1'b0, 7'd32,  7'd5  },
        {1'b1, 7'd127, 16'h7F7F, 1'b1, 7'd5,   7'd127},
        {1'b0, 7'd0,   16'h0000, 1'b0, 7'd33,  7'd32 },
        {1'b1, 7'd64,  16'h6464, 1'b0, 7'd32,  7'd33 },
        {1'b0, 7'd0,   16'h0000, 1'b1, 7'd64,  7'd6  },
        {1'b1, 7'd31,  16'h3131, 1'b0, 7'd65,  7'd64 },
        {1'b0, 7'd0,   16'h0000, 1'b1, 7'd31,  7'd66 },
        {1'b1, 7'd100, 16'hA0A0, 1'b1, 7'd66,  7'd100},
        {1'b0, 7'd0,   16'h0000, 1'b0, 7'd101, 7'd34 },
        {1'b1, 7'd96,  16'h9696, 1'b0, 7'd96,  7'd0  },
        {1'b0, 7'd0,   16'h0000, 1'b1, 7'd97,  7'd5  },
        {1'b1, 7'd33,  16'h3333, 1'b1, 7'd33,  7'd34 },
        {1'b0, 7'd0,   16'h0000, 1'b0, 7'd34,  7'd35 },
        {1'b1, 7'd127, 16'hFFFF, 1'b0, 7'd127, 7'd32 },
        {1'b0, 7'd0,   16'h0000, 1'b1, 7'd32,  7'd127}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < NT; i++) mdl[i] = '0;
        for (int i = 0; i < PT; i++) pmdl[i] = 1'b0;
    endtask

    task automatic mdl_rotate();
        logic [DW-1:0] tmp [NT];
        tmp = mdl;
        for (int i = 0; i < NR; i++) mdl[NS + ((i + 1) % NR)] = tmp[NS + i];
    endtask

    task automatic pmdl_rotate();
        logic tmp [PT];
        tmp = pmdl;
        for (int i = 0; i < PR; i++) pmdl[PS + ((i + 1) % PR)] = tmp[PS + i];
    endtask

    // Drive one cycle, check reads before the edge, then advance the model.
    task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic rot, input logic [AW-1:0] ra0, input logic [AW-1:0] ra1,
                        input string req);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rotate = rot;
        rd0_addr = ra0; rd1_addr = ra1;
        #1;
        chk(req, rd0_data, mdl[ra0]);
        chk(req, rd1_data, mdl[ra1]);
        @(posedge clk);
        if (we) mdl[wa] = wd;
        if (rot) mdl_rotate();
    endtask

    task automatic pstep(input logic we, input logic [PAW-1:0] wa, input logic wd,
                         input logic rot, input logic [PAW-1:0] ra0, input logic [PAW-1:0] ra1,
                         input string req);
        @(negedge clk);
        p_wr_en = we; p_wr_addr = wa; p_wr_data = wd; p_rotate = rot;
        p_rd0_addr = ra0; p_rd1_addr = ra1;
        #1;
        chk(req, {31'd0, p_rd0_data}, {31'd0, pmdl[ra0]});
        chk(req, {31'd0, p_rd1_data}, {31'd0, pmdl[ra1]});
        @(posedge clk);
        if (we) pmdl[wa] = wd;
        if (rot) pmdl_rotate();
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rotate = 1'b0; p_wr_en = 1'b0; p_rotate = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rotate = 1'b0; p_wr_en = 1'b0; p_rotate = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        mdl_clear();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        mdl_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: contents zero after reset
        step(1'b0, '0, '0, 1'b0, 7'd0, 7'd127, "R9");
        step(1'b0, '0, '0, 1'b0, 7'd32, 7'd64, "R9");

        // Table walk: R1/R2 mapping, R7 write with rotate, R8 read of written entry
        for (int i = 0; i < 16; i++) begin
            step(VEC[i][38], VEC[i][37:31], {16'h0, VEC[i][30:15]}, VEC[i][14],
                 VEC[i][13:7], VEC[i][6:0], "R1/R2/R7/R8");
        end

        // R9: reset mid-run clears everything written above
        do_reset();
        step(1'b0, '0, '0, 1'b0, 7'd5, 7'd127, "R9");
        step(1'b0, '0, '0, 1'b0, 7'd31, 7'd33, "R9");

        // R8: read the entry being written, same cycle sees old value
        step(1'b1, 7'd50, 32'hDEAD_0001, 1'b0, 7'd50, 7'd10, "R8");
        step(1'b1, 7'd50, 32'hDEAD_0002, 1'b0, 7'd50, 7'd50, "R8");
        step(1'b1, 7'd10, 32'h0000_0A0A, 1'b0, 7'd10, 7'd50, "R8");

        // R5: X reads as X+1 after one rotation
        step(1'b0, '0, '0, 1'b1, 7'd0, 7'd0, "R5");
        step(1'b0, '0, '0, 1'b0, 7'd51, 7'd50, "R5");
        chk("R5", rd0_data, 32'hDEAD_0002);

        // R6: top entry wraps to lowest rotating number
        step(1'b1, 7'd127, 32'hC0DE_007F, 1'b1, 7'd127, 7'd32, "R6");
        step(1'b0, '0, '0, 1'b0, 7'd32, 7'd127, "R6");
        chk("R6", rd0_data, 32'hC0DE_007F);

        // R7: write and rotate in the same cycle
        step(1'b1, 7'd70, 32'h7070_7070, 1'b1, 7'd70, 7'd71, "R7");
        step(1'b0, '0, '0, 1'b0, 7'd71, 7'd70, "R7");
        chk("R7", rd0_data, 32'h7070_7070);

        // R10: logical 32 -> 34 after two rotations, not clobbered by a later write to 32
        step(1'b1, 7'd32, 32'hAAAA_0032, 1'b0, 7'd32, 7'd34, "R10");
        step(1'b0, '0, '0, 1'b1, 7'd32, 7'd33, "R10");
        step(1'b1, 7'd32, 32'hBBBB_0032, 1'b0, 7'd33, 7'd32, "R10");
        step(1'b0, '0, '0, 1'b1, 7'd33, 7'd32, "R10");
        step(1'b0, '0, '0, 1'b0, 7'd34, 7'd33, "R10");
        chk("R10", rd0_data, 32'hAAAA_0032);
        chk("R10", rd1_data, 32'hBBBB_0032);

        // R12-style static stability is R1: static entry unchanged across rotations
        step(1'b1, 7'd7, 32'h0000_0777, 1'b0, 7'd7, 7'd0, "R1");
        step(1'b0, '0, '0, 1'b1, 7'd7, 7'd0, "R1");
        step(1'b0, '0, '0, 1'b1, 7'd7, 7'd0, "R1");
        step(1'b0, '0, '0, 1'b0, 7'd7, 7'd31, "R1");
        chk("R1", rd0_data, 32'h0000_0777);

        // R3/R4: full revolution of the base, including wrap below zero
        step(1'b1, 7'd40, 32'h4040_4040, 1'b0, 7'd40, 7'd41, "R4");
        for (int i = 0; i < NR; i++) begin
            step(1'b0, '0, '0, 1'b1, AW'(NS + (i % NR)), AW'(NS + ((i + 8) % NR)), "R3/R4");
        end
        step(1'b0, '0, '0, 1'b0, 7'd40, 7'd34, "R4");
        chk("R4", rd0_data, 32'h4040_4040);

        // R11: flag-file configuration 16 static / 48 rotating
        idle();
        pstep(1'b1, 6'd16, 1'b1, 1'b0, 6'd16, 6'd3, "R11");
        pstep(1'b1, 6'd3, 1'b1, 1'b0, 6'd3, 6'd17, "R11");
        pstep(1'b1, 6'd63, 1'b1, 1'b1, 6'd63, 6'd16, "R11");
        pstep(1'b0, '0, 1'b0, 1'b0, 6'd17, 6'd16, "R11");
        chk("R11", {31'd0, p_rd0_data}, 32'd1);
        chk("R11", {31'd0, p_rd1_data}, 32'd1);
        pstep(1'b0, '0, 1'b0, 1'b1, 6'd3, 6'd18, "R11");
        pstep(1'b0, '0, 1'b0, 1'b0, 6'd3, 6'd18, "R11");
        chk("R11", {31'd0, p_rd0_data}, 32'd1);
        chk("R11", {31'd0, p_rd1_data}, 32'd1);

        idle();
        summary();
        $finish;
    end

endmodule